// File: doc/BRIEF.md
# Embedded-Clock Serializer Framer

This block turns a stream of 10-bit parallel words into a serial bit stream. Each word is wrapped in a 12-bit frame: a leading clock bit that is always 1, the ten data bits with the least significant bit first, and a trailing clock bit that is always 0. Because a frame always ends low and the next one always starts high, the line has at least one rising edge per frame. A receiver can recover the word clock from that edge without a separate clock wire.

The parallel clock is sampled in the fast system clock domain, and a select input picks whether its rising or its falling edge captures the input word. A one-cycle bit enable, running at twelve times the word rate, paces the shifter. A word is taken into a frame only at a frame boundary. While either of two sync inputs is high, the block sends a lock pattern in place of data so that a receiver can acquire lock. A driver enable and a powerdown input control the output enable. Powerdown also stops transmission and clears the block.

Top module: `emb_clk_serializer`

## Requirements
- R1: `edge_sel`=1 captures `din` at a rising edge of `pclk`; `edge_sel`=0 captures it at a falling edge. The other edge is ignored.
- R2: One frame bit is shown per `bit_en` pulse. While `bit_en` is low, `ser_dat` and the bit position do not change.
- R3: A data frame, in send order, is bit 0 = 1, then bits 1..10 = `din[0]`..`din[9]`, then bit 11 = 0.
- R4: Every 12-bit frame, data or sync, starts with 1 and ends with 0, so each frame boundary has a rising transition.
- R5: If `sync_a` or `sync_b` is high at a frame boundary, the next frame is six 1s followed by six 0s. This repeats while the request stays high, and data resumes when it is released.
- R6: A word captured in the middle of a frame does not change that frame. It is sent from the next frame boundary on.
- R7: `ser_oe` is high only when `drv_en` is high and `pwr_dn` is low. When `drv_en` is low, framing continues on `ser_dat`.
- R8: `pwr_dn` high forces `ser_dat` low from the next clock, ignores captures, and discards the held word. After release the line stays low until a new word is captured.
- R9: After reset `ser_dat` is low and no frame is sent until a word has been captured or sync is requested.
- R10: If no new word is captured, the last word is sent again in every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle bit-rate enable (×12 word rate) |
| pclk | input | 1 | Parallel word clock, sampled on `clk` |
| edge_sel | input | 1 | 1: capture on rising `pclk`; 0: capture on falling `pclk` |
| din | input | 10 | Parallel word: 8 data bits plus 2 control bits |
| sync_a | input | 1 | Sync pattern request |
| sync_b | input | 1 | Second sync pattern request |
| drv_en | input | 1 | Output driver enable |
| pwr_dn | input | 1 | Powerdown |
| ser_dat | output | 1 | Serial line value |
| ser_oe | output | 1 | Line drive enable (low = high impedance) |

## Verification
A word is captured at the `clk` edge where the selected `pclk` level is first seen. The first frame bit appears right after the edge that consumes the next boundary `bit_en`, and each later bit follows one `bit_en`-consuming edge after the one before. The bench drives each `bit_en` pulse on a falling edge of `clk`, samples `ser_dat` at the next falling edge, and then samples again one idle cycle later to confirm the value holds. Powerdown is checked one clock after it is asserted, and `ser_oe` is checked in the same cycle as its inputs change, because it is combinational.

// File: rtl/emb_clk_serializer.sv
module emb_clk_serializer #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          pclk,
  input  logic          edge_sel,
  input  logic [DW-1:0] din,
  input  logic          sync_a,
  input  logic          sync_b,
  input  logic          drv_en,
  input  logic          pwr_dn,
  output logic          ser_dat,
  output logic          ser_oe
);
  localparam int FW = DW + 2;
  localparam int CW = $clog2(FW);
  localparam logic [FW-1:0] SYNC_PAT = {{(FW - FW/2){1'b0}}, {(FW/2){1'b1}}};

  logic [FW-1:0] shreg;
  logic [CW-1:0] cnt;
  logic [DW-1:0] hold;
  logic          active, have_word, pclk_q;

  wire pclk_rise = pclk & ~pclk_q;
  wire pclk_fall = ~pclk & pclk_q;
  wire cap       = edge_sel ? pclk_rise : pclk_fall;
  wire sync_req  = sync_a | sync_b;
  wire boundary  = bit_en & (~active | (cnt == CW'(FW - 1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      cnt       <= '0;
      hold      <= '0;
      active    <= 1'b0;
      have_word <= 1'b0;
      pclk_q    <= 1'b0;
    end else if (pwr_dn) begin
      shreg     <= '0;
      cnt       <= '0;
      active    <= 1'b0;
      have_word <= 1'b0;
      pclk_q    <= pclk;
    end else begin
      pclk_q <= pclk;
      if (cap) begin
        hold      <= din;
        have_word <= 1'b1;
      end
      if (boundary) begin
        cnt <= '0;
        if (sync_req) begin
          shreg  <= SYNC_PAT;
          active <= 1'b1;
        end else if (have_word) begin
          shreg  <= {1'b0, hold, 1'b1};
          active <= 1'b1;
        end else begin
          shreg  <= '0;
          active <= 1'b0;
        end
      end else if (bit_en && active) begin
        shreg <= shreg >> 1;
        cnt   <= cnt + 1'b1;
      end
    end
  end

  assign ser_dat = active & shreg[0];
  assign ser_oe  = drv_en & ~pwr_dn;
endmodule

// File: rtl/emb_clk_serializer_chk.sv
module emb_clk_serializer_chk #(
  parameter int FW = 12,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          drv_en,
  input logic          pwr_dn,
  input logic          ser_dat,
  input logic          ser_oe,
  input logic          active,
  input logic [CW-1:0] cnt
);
  AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt == '0) |-> ser_dat); // R4
  AST_STOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt == CW'(FW - 1)) |-> !ser_dat); // R4
  AST_PACE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !pwr_dn) |=> $stable(cnt)); // R2
  AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!ser_dat && !active)); // R8
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_en || pwr_dn) |-> !ser_oe); // R7
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !ser_dat); // R9
endmodule

bind emb_clk_serializer emb_clk_serializer_chk #(.FW(FW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .drv_en(drv_en), .pwr_dn(pwr_dn),
  .ser_dat(ser_dat), .ser_oe(ser_oe), .active(active), .cnt(cnt)
);

// File: tb/tb_emb_clk_serializer.sv
module tb_emb_clk_serializer;
  logic clk = 0, rst_n = 0, bit_en = 0, pclk = 0, edge_sel = 1;
  logic [9:0] din = '0;
  logic sync_a = 0, sync_b = 0, drv_en = 1, pwr_dn = 0;
  logic ser_dat, ser_oe;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  emb_clk_serializer dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pclk(pclk), .edge_sel(edge_sel),
    .din(din), .sync_a(sync_a), .sync_b(sync_b), .drv_en(drv_en), .pwr_dn(pwr_dn),
    .ser_dat(ser_dat), .ser_oe(ser_oe)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_step(output logic v);
    @(negedge clk) bit_en = 1;
    @(negedge clk) bit_en = 0;
    v = ser_dat;
    @(negedge clk);
    check("R2 hold between enables", ser_dat, v);
  endtask

  task automatic cap_word(input logic [9:0] d, input logic e);
    @(negedge clk) edge_sel = e; pclk = e ? 1'b0 : 1'b1; din = ~d;
    @(negedge clk) pclk = e ? 1'b1 : 1'b0; din = d;
    @(negedge clk) din = ~d;
  endtask

  task automatic read_frame(output logic [11:0] f);
    for (int k = 0; k < 12; k++) bit_step(f[k]);
  endtask

  function automatic logic [11:0] exp_frame(input logic [9:0] d);
    logic [11:0] r;
    r[0] = 1'b1;
    for (int i = 0; i < 10; i++) r[i+1] = d[i];
    r[11] = 1'b0;
    return r;
  endfunction

  function automatic logic [11:0] exp_sync();
    logic [11:0] r;
    for (int i = 0; i < 12; i++) r[i] = (i < 6);
    return r;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] f;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset line low", ser_dat, 0);
    check("R7 oe with driver on", ser_oe, 1);
    for (int k = 0; k < 6; k++) begin
      bit_step(v);
      check("R9 idle before first word", v, 0);
    end

    // R1 R3 R4: sweep all words, alternating capture edge
    for (int w = 0; w < 1024; w++) begin
      cap_word(10'(w), w[0]);
      read_frame(f);
      check("R3 frame layout", f, exp_frame(10'(w)));
      check("R4 edge at boundary", {f[0], f[11]}, 2'b10);
    end

    // R10 repeat last word
    read_frame(f);
    check("R10 word repeated", f, exp_frame(10'd1023));

    // R6 mid-frame capture
    cap_word(10'h2A5, 1);
    read_frame(f);
    for (int k = 0; k < 12; k++) begin
      bit_step(f[k]);
      if (k == 4) cap_word(10'h15A, 0);
    end
    check("R6 current frame unchanged", f, exp_frame(10'h2A5));
    read_frame(f);
    check("R6 new word next frame", f, exp_frame(10'h15A));

    // R5 sync on either input
    sync_a = 1;
    read_frame(f);
    check("R5 sync via a", f, exp_sync());
    read_frame(f);
    check("R5 sync repeats", f, exp_sync());
    sync_a = 0; sync_b = 1;
    read_frame(f);
    check("R5 sync via b", f, exp_sync());
    sync_b = 0;
    read_frame(f);
    check("R5 data resumes", f, exp_frame(10'h15A));

    // R7 driver off keeps framing
    @(negedge clk) drv_en = 0;
    #1 check("R7 oe off", ser_oe, 0);
    cap_word(10'h0F0, 1);
    read_frame(f);
    check("R7 framing continues", f, exp_frame(10'h0F0));
    drv_en = 1;
    #1 check("R7 oe back on", ser_oe, 1);

    // R8 powerdown mid-frame
    for (int k = 0; k < 3; k++) bit_step(v);
    @(negedge clk) pwr_dn = 1;
    #1 check("R8 oe off in powerdown", ser_oe, 0);
    @(negedge clk);
    check("R8 line low", ser_dat, 0);
    cap_word(10'h3FF, 1);
    for (int k = 0; k < 4; k++) begin
      bit_step(v);
      check("R8 quiet in powerdown", v, 0);
    end
    @(negedge clk) pwr_dn = 0;
    for (int k = 0; k < 14; k++) begin
      bit_step(v);
      check("R8 word discarded", v, 0);
    end
    cap_word(10'h1C3, 0);
    read_frame(f);
    check("R8 resumes after new word", f, exp_frame(10'h1C3));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule